// File: doc/BRIEF.md
# Capture Timer with Overflow Extension

This block is a free-running up counter with one capture channel. A second counter of the same kind counts the wraps of the first. Together the two form an extended timestamp: the wrap count is the upper half and the running count is the lower half. It suits interval measurements longer than one counter period, for example timing the discharge phase of an integrating converter.

A capture event latches both halves on the same clock edge. Software therefore always reads a consistent pair. A capture taken just below the top of the range is reported with the wrap count from before the next wrap, even if that wrap arrives only a few ticks later.

The counters advance on a prescaled tick, qualified by an enable. Capture is detected by a two-state machine:
- `CAP_WAIT_LOW` means the capture input must first be seen low. It moves to `CAP_ARMED` when the input is sampled low.
- `CAP_ARMED` stays there while the input is low. When the input is sampled high, it takes a capture (the "fire" transition) and returns to `CAP_WAIT_LOW`.
- Reset enters `CAP_WAIT_LOW`.

Top module: `cap_timer_ext`

## Requirements
- R1: The low counter (LO_W bits, default 16) steps up by one on each clock edge where `en` and `tick` are both high. On any other edge it holds. It wraps from all-ones to 0.
- R2: When the low counter wraps, `lo_wrap` is high for exactly one cycle: the cycle in which the counter holds 0 after the wrap.
- R3: The high counter (HI_W bits, default 16) steps up by one for each low-counter wrap and wraps at all-ones. When it wraps, `hi_wrap` pulses with the same timing as `lo_wrap`.
- R4: A capture event is an edge where `cap_in` is sampled high in state `CAP_ARMED`. The state is armed only after `cap_in` has been sampled low. Two captures are at least two cycles apart.
- R5: On a capture edge, `cap_lo` and `cap_hi` take the values both counters hold just after that edge. `cap_valid` is high for exactly the following cycle.
- R6: Captured values hold until the next capture. A capture near the top of the range that is followed a few ticks later by a wrap keeps the wrap count from before that wrap.
- R7: When a capture and a low wrap fall on the same edge, `cap_lo` is 0 and `cap_hi` already includes that wrap.
- R8: After reset, a `cap_in` that is held high causes no capture until it has been sampled low.
- R9: Synchronous reset (`rst` high) clears both counters, both capture registers, `cap_valid` and both wrap pulses.
- R10: With `en` low, both counters hold. Captures are still taken and report the frozen values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counting enable |
| tick | input | 1 | Prescaled count tick, one cycle per count |
| cap_in | input | 1 | Capture request, synchronous level |
| cap_lo | output | LO_W | Captured low count |
| cap_hi | output | HI_W | Captured wrap count |
| cap_valid | output | 1 | One-cycle pulse after each new captured pair |
| lo_wrap | output | 1 | Zero event of the low counter |
| hi_wrap | output | 1 | Wrap event of the high counter |

## Verification
The bench runs the block with reduced widths so that both counters wrap many times. It mixes sparse and dense ticks, enable dropouts, and capture toggles, and compares every output against a model on every cycle.

Directed cases separate the individual behaviours:
- A capture input held through reset shows whether the state machine insists on a low sample first.
- Captures with `en` or `tick` low show that the counters are frozen.
- A capture a few ticks below the top, followed by a wrap, shows that the wrap count is not taken late.
- A capture on the wrap edge itself shows that both halves are taken from the same post-edge state.

// File: rtl/cte_pkg.sv
package cte_pkg;

    // Capture detector states
    typedef enum logic {
        CAP_WAIT_LOW = 1'b0,
        CAP_ARMED    = 1'b1
    } cap_state_t;

endpackage

// File: rtl/cte_wrap_counter.sv
module cte_wrap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic [W-1:0] q_nxt,
    output logic         wrap_now,
    output logic         wrap_pulse
);

    localparam logic [W-1:0] TOP = '1;

    assign wrap_now = inc && (q == TOP);
    assign q_nxt    = inc ? q + W'(1) : q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            q          <= q_nxt;
            wrap_pulse <= wrap_now;
        end
    end

    // R1 / R3: one step per increment request, modulo 2**W
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        inc |=> (q == $past(q) + W'(1)));

    // R1 / R10: no request, no movement
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(q));

    // R2: a wrap pulse is only seen while the count reads zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (q == '0));

endmodule

// File: rtl/cte_cap_fsm.sv
module cte_cap_fsm
    import cte_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_in,
    output logic fire
);

    cap_state_t state;
    cap_state_t state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= CAP_WAIT_LOW;
        else     state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            CAP_WAIT_LOW: state_nxt = cap_in ? CAP_WAIT_LOW : CAP_ARMED;
            CAP_ARMED:    state_nxt = cap_in ? CAP_WAIT_LOW : CAP_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        unique case (state)
            CAP_WAIT_LOW: fire = 1'b0;
            CAP_ARMED:    fire = cap_in;
        endcase
    end

    // R4: captures never come back to back
    p_gap_r4: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R8: every capture is preceded by a low sample of the input
    p_need_low_r8: assert property (@(posedge clk) disable iff (rst)
        fire |-> !$past(cap_in));

endmodule

// File: rtl/cte_cap_regs.sv
module cte_cap_regs #(
    parameter int LW = 16,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [LW-1:0] lo_nxt,
    input  logic [HW-1:0] hi_nxt,
    output logic [LW-1:0] cap_lo,
    output logic [HW-1:0] cap_hi,
    output logic          cap_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo    <= '0;
            cap_hi    <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= fire;
            if (fire) begin
                cap_lo <= lo_nxt;
                cap_hi <= hi_nxt;
            end
        end
    end

    // R6: captured pair is frozen between captures
    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(cap_lo) && $stable(cap_hi)));

endmodule

// File: rtl/cap_timer_ext.sv
module cap_timer_ext #(
    parameter int LO_W = 16,
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic            cap_in,
    output logic [LO_W-1:0] cap_lo,
    output logic [HI_W-1:0] cap_hi,
    output logic            cap_valid,
    output logic            lo_wrap,
    output logic            hi_wrap
);

    logic            advance;
    logic [LO_W-1:0] lo_q;
    logic [LO_W-1:0] lo_nxt;
    logic            lo_wrap_now;
    logic [HI_W-1:0] hi_q;
    logic [HI_W-1:0] hi_nxt;
    logic            hi_wrap_now;
    logic            fire;

    assign advance = en && tick;

    cte_wrap_counter #(.W(LO_W)) i_lo (
        .clk        (clk),
        .rst        (rst),
        .inc        (advance),
        .q          (lo_q),
        .q_nxt      (lo_nxt),
        .wrap_now   (lo_wrap_now),
        .wrap_pulse (lo_wrap)
    );

    cte_wrap_counter #(.W(HI_W)) i_hi (
        .clk        (clk),
        .rst        (rst),
        .inc        (lo_wrap_now),
        .q          (hi_q),
        .q_nxt      (hi_nxt),
        .wrap_now   (hi_wrap_now),
        .wrap_pulse (hi_wrap)
    );

    cte_cap_fsm i_fsm (
        .clk    (clk),
        .rst    (rst),
        .cap_in (cap_in),
        .fire   (fire)
    );

    cte_cap_regs #(.LW(LO_W), .HW(HI_W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .lo_nxt    (lo_nxt),
        .hi_nxt    (hi_nxt),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .cap_valid (cap_valid)
    );

    // R5 / R7: the captured pair equals the counters right after the capture edge
    p_pair_r5: assert property (@(posedge clk) disable iff (rst)
        fire |=> ((cap_lo == lo_q) && (cap_hi == hi_q) && cap_valid));

    // R3: the high counter can only wrap on a low wrap
    p_hi_follow_r3: assert property (@(posedge clk) disable iff (rst)
        hi_wrap_now |-> lo_wrap_now);

    // R10: enable low freezes both halves
    p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: tb/test_cap_timer_ext.sv
module test_cap_timer_ext;

    localparam int LW   = 6;
    localparam int HW   = 3;
    localparam int LMAX = (1 << LW) - 1;
    localparam int HMAX = (1 << HW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          tick = 1'b0;
    logic          cap_in = 1'b1;
    logic [LW-1:0] cap_lo;
    logic [HW-1:0] cap_hi;
    logic          cap_valid;
    logic          lo_wrap;
    logic          hi_wrap;

    int n_chk  = 0;
    int n_fail = 0;
    int hi_seen = 0;

    // model state
    int m_lo = 0, m_hi = 0, m_clo = 0, m_chi = 0;
    bit m_armed = 1'b0;
    bit m_v = 1'b0, m_wl = 1'b0, m_wh = 1'b0;

    always #10 clk = ~clk;

    cap_timer_ext #(.LO_W(LW), .HI_W(HW)) i_cap_timer_ext (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tick      (tick),
        .cap_in    (cap_in),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .cap_valid (cap_valid),
        .lo_wrap   (lo_wrap),
        .hi_wrap   (hi_wrap)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Reference model: one clock edge
    task automatic mdl(input bit e, input bit t, input bit c);
        bit adv  = e && t;
        bit fire = m_armed && c;
        m_wl = adv && (m_lo == LMAX);
        if (adv) m_lo = (m_lo + 1) & LMAX;
        m_wh = m_wl && (m_hi == HMAX);
        if (m_wl) m_hi = (m_hi + 1) & HMAX;
        m_armed = fire ? 1'b0 : (m_armed || !c);
        if (fire) begin
            m_clo = m_lo;
            m_chi = m_hi;
        end
        m_v = fire;
    endtask

    task automatic step(input bit e, input bit t, input bit c);
        en = e; tick = t; cap_in = c;
        mdl(e, t, c);
        @(posedge clk);
        #2;
        chk("R2 lo_wrap", int'(lo_wrap), int'(m_wl));
        chk("R3 hi_wrap", int'(hi_wrap), int'(m_wh));
        chk("R5 cap_valid", int'(cap_valid), int'(m_v));
        chk("R5 cap_lo", int'(cap_lo), m_clo);
        chk("R5 cap_hi", int'(cap_hi), m_chi);
        if (hi_wrap) hi_seen++;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int h0;
        bit c;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 cap_lo", int'(cap_lo), 0);
        chk("R9 cap_hi", int'(cap_hi), 0);
        chk("R9 cap_valid", int'(cap_valid), 0);
        chk("R9 wraps", int'(lo_wrap) + int'(hi_wrap), 0);
        rst = 1'b0;

        // R8: held high out of reset, no capture
        repeat (4) begin
            step(1, 1, 1);
            chk("R8 no capture while held", int'(cap_valid), 0);
        end
        step(1, 1, 0);
        step(1, 1, 1);
        chk("R4 capture after low", int'(cap_valid), 1);
        chk("R4 cap_lo", int'(cap_lo), 6);
        chk("R4 cap_hi", int'(cap_hi), 0);

        // R10: enable low freezes, capture still taken
        repeat (5) step(0, 1, 0);
        step(0, 1, 1);
        chk("R10 capture taken", int'(cap_valid), 1);
        chk("R10 frozen value", int'(cap_lo), 6);
        // R1: tick low holds
        repeat (3) step(1, 0, 0);
        step(1, 0, 1);
        chk("R1 held without tick", int'(cap_lo), 6);

        // R6: capture just below the top, wrap a few ticks later
        while (m_lo != 59) step(1, 1, 0);
        h0 = m_hi;
        step(1, 1, 1);
        chk("R6 cap_lo near top", int'(cap_lo), 60);
        repeat (6) step(1, 1, 0);
        chk("R6 cap_lo kept", int'(cap_lo), 60);
        chk("R6 cap_hi pre-wrap", int'(cap_hi), h0);
        step(1, 1, 1);
        chk("R6 next capture lo", int'(cap_lo), 3);
        chk("R6 next capture hi", int'(cap_hi), (h0 + 1) & HMAX);

        // R7: capture on the wrap edge
        while (m_lo != LMAX) step(1, 1, 0);
        h0 = m_hi;
        step(1, 1, 1);
        chk("R7 cap_lo zero", int'(cap_lo), 0);
        chk("R7 cap_hi includes wrap", int'(cap_hi), (h0 + 1) & HMAX);
        chk("R7 lo_wrap same cycle", int'(lo_wrap), 1);

        // Random traffic
        c = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            bit e = ($urandom % 10) != 0;
            bit t = ($urandom % 3) != 0;
            if (($urandom % 4) == 0) c = ~c;
            step(e, t, c);
        end
        chk("R3 hi wraps observed", int'(hi_seen > 0), 1);

        summary();
        $finish;
    end

endmodule